// File: doc/BRIEF.md
# AGP Request to HyperTransport Packet Translator

This block sits between an AGP graphics master and a HyperTransport link. It takes requests from two independent AGP channels and turns each into a HyperTransport request header. The high-priority channel carries reads and writes. The low-priority channel carries reads, writes, flushes and fences. The header carries the command, the posted attribute, PassPW and RespPassPW. Data movement, byte-mask splitting and serialization belong to other blocks.

Each channel has its own valid/ready request port and its own counters. Each channel keeps one counter of outstanding writes and one of outstanding reads. A counter rises when its packet is handed over and falls on a completion pulse. The low-priority channel stalls reads, flushes and fences on these counters, so its ordering rules hold at the target. A flush or a fence can retire without producing a packet. The two channels share one valid/ready packet output. When both have a packet to send, the high-priority channel goes first. A stall in one channel never holds the other.

Top module: `agp_ht_xlat`

## Requirements
- R1: A high-priority write produces cmd 2'b01 (sized write), posted = 1, RespPassPW = 0, and PassPW equal to `hp_pass_pw_i`.
- R2: A high-priority read produces cmd 2'b00 (sized read), posted = 0, RespPassPW = 1, and PassPW equal to `hp_pass_pw_i`.
- R3: A low-priority write (op 2'b01) produces cmd 2'b01, posted = 0, PassPW = 1, RespPassPW = 0.
- R4: A low-priority read (op 2'b00) produces cmd 2'b00, posted = 0, PassPW = 1, RespPassPW = 1.
- R5: A low-priority read is not accepted and offers no packet while any low-priority write is outstanding.
- R6: With `flush_pkt_i` = 0, a low-priority flush (op 2'b10) produces no packet. It is accepted only once no low-priority write is outstanding.
- R7: With `flush_pkt_i` = 1, a low-priority flush waits for the same condition as R6. It then produces cmd 2'b10 (Flush) with PassPW = 0, posted = 0, RespPassPW = 0.
- R8: A low-priority fence (op 2'b11) produces no packet. It is accepted only when no low-priority read or write is outstanding. Later low-priority requests wait behind it. All counters are zero after reset.
- R9: The high-priority channel is never stalled by low-priority state. A high-priority read is issued while high-priority writes are outstanding.
- R10: When both channels offer a packet, the high-priority packet is sent (`pkt_hi_o` = 1) and the low-priority request is held. With `pkt_ready_i` = 0, no packet-producing request is accepted.
- R11: A request whose outstanding counter holds its maximum of 2^CNT_W-1 is stalled until a completion lowers that counter.
- R12: Low-priority writes are issued back to back, without waiting for earlier writes to complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hp_pass_pw_i | input | 1 | PassPW value used for high-priority packets |
| flush_pkt_i | input | 1 | 1: a low-priority flush emits a Flush packet |
| hp_req_valid_i | input | 1 | High-priority request valid |
| hp_req_wr_i | input | 1 | High-priority request is a write (0: read) |
| hp_req_ready_o | output | 1 | High-priority request accepted |
| lp_req_valid_i | input | 1 | Low-priority request valid |
| lp_req_op_i | input | 2 | 00 read, 01 write, 10 flush, 11 fence |
| lp_req_ready_o | output | 1 | Low-priority request accepted |
| pkt_valid_o | output | 1 | Packet header valid |
| pkt_ready_i | input | 1 | Link accepts the header |
| pkt_cmd_o | output | 2 | 00 sized read, 01 sized write, 10 flush |
| pkt_posted_o | output | 1 | Posted attribute |
| pkt_pass_pw_o | output | 1 | PassPW bit |
| pkt_resp_pass_pw_o | output | 1 | RespPassPW bit |
| pkt_hi_o | output | 1 | Packet comes from the high-priority channel |
| hp_wr_done_i | input | 1 | One high-priority write completed |
| hp_rd_done_i | input | 1 | One high-priority read response returned |
| lp_wr_done_i | input | 1 | One low-priority write completed |
| lp_rd_done_i | input | 1 | One low-priority read response returned |

## Verification
The request-to-packet path has no register in it. The header fields, `pkt_valid_o` and both ready outputs follow a request in the same cycle. The bench therefore drives on the falling edge and reads those outputs shortly afterwards, before the next rising edge. A counter changes on the rising edge that completes a handshake or sees a completion pulse. A stall caused by it shows up, or clears, one cycle after that stimulus. Each stall check is sampled in the cycle after the edge that moved the counter, with the stalled request held valid throughout.

// File: rtl/agp_ht_pkg.sv
package agp_ht_pkg;
  typedef enum logic [1:0] {
    LP_RD    = 2'b00,
    LP_WR    = 2'b01,
    LP_FLUSH = 2'b10,
    LP_FENCE = 2'b11
  } lp_op_e;

  typedef enum logic [1:0] {
    HT_RD    = 2'b00,
    HT_WR    = 2'b01,
    HT_FLUSH = 2'b10
  } ht_cmd_e;

  typedef struct packed {
    ht_cmd_e cmd;
    logic    posted;
    logic    pass_pw;
    logic    resp_pass_pw;
  } ht_hdr_t;
endpackage

// File: rtl/agp_ht_cnt.sv
module agp_ht_cnt #(
  parameter int W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o,
  output logic full_o
);
  logic [W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);
  assign full_o = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (inc_i && !dec_i && !full_o) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i && !zero_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/agp_ht_hp_chan.sv
module agp_ht_hp_chan
  import agp_ht_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    req_wr_i,
  input  logic    pass_pw_i,
  input  logic    grant_i,
  input  logic    wr_done_i,
  input  logic    rd_done_i,
  output logic    req_ready_o,
  output logic    want_o,
  output ht_hdr_t hdr_o
);
  logic wr_zero, wr_full, rd_zero, rd_full;
  logic ok, fire;

  // only the counter limit can stall this channel
  assign ok          = req_wr_i ? !wr_full : !rd_full;
  assign want_o      = req_valid_i && ok;
  assign req_ready_o = ok && grant_i;
  assign fire        = req_valid_i && req_ready_o;

  always_comb begin
    hdr_o.cmd          = req_wr_i ? HT_WR : HT_RD;
    hdr_o.posted       = req_wr_i;
    hdr_o.pass_pw      = pass_pw_i;
    hdr_o.resp_pass_pw = !req_wr_i;
  end

  agp_ht_cnt #(.W(CNT_W)) u_wr_cnt (
    .clk_i, .rst_ni, .inc_i(fire && req_wr_i), .dec_i(wr_done_i),
    .zero_o(wr_zero), .full_o(wr_full)
  );
  agp_ht_cnt #(.W(CNT_W)) u_rd_cnt (
    .clk_i, .rst_ni, .inc_i(fire && !req_wr_i), .dec_i(rd_done_i),
    .zero_o(rd_zero), .full_o(rd_full)
  );

  logic unused_zero;
  assign unused_zero = wr_zero ^ rd_zero;
endmodule

// File: rtl/agp_ht_lp_chan.sv
module agp_ht_lp_chan
  import agp_ht_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [1:0] req_op_i,
  input  logic       flush_pkt_i,
  input  logic       grant_i,
  input  logic       wr_done_i,
  input  logic       rd_done_i,
  output logic       req_ready_o,
  output logic       want_o,
  output ht_hdr_t    hdr_o
);
  lp_op_e op;
  logic   wr_zero, wr_full, rd_zero, rd_full;
  logic   ok, needs_pkt, fire;

  assign op = lp_op_e'(req_op_i);

  always_comb begin
    ok        = 1'b0;
    needs_pkt = 1'b1;
    hdr_o     = '{cmd: HT_RD, posted: 1'b0, pass_pw: 1'b1, resp_pass_pw: 1'b1};
    unique case (op)
      LP_RD: ok = wr_zero && !rd_full;
      LP_WR: begin
        ok                 = !wr_full;
        hdr_o.cmd          = HT_WR;
        hdr_o.resp_pass_pw = 1'b0;
      end
      LP_FLUSH: begin
        ok                 = wr_zero;
        needs_pkt          = flush_pkt_i;
        hdr_o.cmd          = HT_FLUSH;
        hdr_o.pass_pw      = 1'b0;
        hdr_o.resp_pass_pw = 1'b0;
      end
      LP_FENCE: begin
        ok        = wr_zero && rd_zero;
        needs_pkt = 1'b0;
      end
      default: ok = 1'b0;
    endcase
  end

  assign want_o      = req_valid_i && ok && needs_pkt;
  assign req_ready_o = ok && (!needs_pkt || grant_i);
  assign fire        = req_valid_i && req_ready_o;

  agp_ht_cnt #(.W(CNT_W)) u_wr_cnt (
    .clk_i, .rst_ni, .inc_i(fire && op == LP_WR), .dec_i(wr_done_i),
    .zero_o(wr_zero), .full_o(wr_full)
  );
  agp_ht_cnt #(.W(CNT_W)) u_rd_cnt (
    .clk_i, .rst_ni, .inc_i(fire && op == LP_RD), .dec_i(rd_done_i),
    .zero_o(rd_zero), .full_o(rd_full)
  );
endmodule

// File: rtl/agp_ht_xlat.sv
module agp_ht_xlat
  import agp_ht_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hp_pass_pw_i,
  input  logic       flush_pkt_i,
  input  logic       hp_req_valid_i,
  input  logic       hp_req_wr_i,
  output logic       hp_req_ready_o,
  input  logic       lp_req_valid_i,
  input  logic [1:0] lp_req_op_i,
  output logic       lp_req_ready_o,
  output logic       pkt_valid_o,
  input  logic       pkt_ready_i,
  output logic [1:0] pkt_cmd_o,
  output logic       pkt_posted_o,
  output logic       pkt_pass_pw_o,
  output logic       pkt_resp_pass_pw_o,
  output logic       pkt_hi_o,
  input  logic       hp_wr_done_i,
  input  logic       hp_rd_done_i,
  input  logic       lp_wr_done_i,
  input  logic       lp_rd_done_i
);
  logic    hp_want, lp_want;
  ht_hdr_t hp_hdr, lp_hdr, hdr;

  agp_ht_hp_chan #(.CNT_W(CNT_W)) u_hp (
    .clk_i, .rst_ni,
    .req_valid_i(hp_req_valid_i), .req_wr_i(hp_req_wr_i), .pass_pw_i(hp_pass_pw_i),
    .grant_i(pkt_ready_i), .wr_done_i(hp_wr_done_i), .rd_done_i(hp_rd_done_i),
    .req_ready_o(hp_req_ready_o), .want_o(hp_want), .hdr_o(hp_hdr)
  );

  // low priority gets the link only when high priority has nothing to send
  agp_ht_lp_chan #(.CNT_W(CNT_W)) u_lp (
    .clk_i, .rst_ni,
    .req_valid_i(lp_req_valid_i), .req_op_i(lp_req_op_i), .flush_pkt_i(flush_pkt_i),
    .grant_i(pkt_ready_i && !hp_want), .wr_done_i(lp_wr_done_i), .rd_done_i(lp_rd_done_i),
    .req_ready_o(lp_req_ready_o), .want_o(lp_want), .hdr_o(lp_hdr)
  );

  assign hdr                = hp_want ? hp_hdr : lp_hdr;
  assign pkt_valid_o        = hp_want || lp_want;
  assign pkt_hi_o           = hp_want;
  assign pkt_cmd_o          = hdr.cmd;
  assign pkt_posted_o       = hdr.posted;
  assign pkt_pass_pw_o      = hdr.pass_pw;
  assign pkt_resp_pass_pw_o = hdr.resp_pass_pw;
endmodule

// File: rtl/agp_ht_xlat_chk.sv
module agp_ht_xlat_chk #(
  parameter int CNT_W = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hp_pass_pw_i,
  input logic       flush_pkt_i,
  input logic       hp_req_valid_i,
  input logic       hp_req_wr_i,
  input logic       hp_req_ready_o,
  input logic       lp_req_valid_i,
  input logic [1:0] lp_req_op_i,
  input logic       lp_req_ready_o,
  input logic       pkt_valid_o,
  input logic       pkt_ready_i,
  input logic [1:0] pkt_cmd_o,
  input logic       pkt_posted_o,
  input logic       pkt_pass_pw_o,
  input logic       pkt_resp_pass_pw_o,
  input logic       pkt_hi_o,
  input logic       lp_wr_done_i,
  input logic       lp_rd_done_i
);
  localparam int MAX = (1 << CNT_W) - 1;

  logic hp_acc, lp_acc, lp_pkt_op;
  logic [CNT_W:0] wr_out_q, rd_out_q;

  assign hp_acc    = hp_req_valid_i && hp_req_ready_o;
  assign lp_acc    = lp_req_valid_i && lp_req_ready_o;
  assign lp_pkt_op = (lp_req_op_i[1] == 1'b0) || (lp_req_op_i == 2'b10 && flush_pkt_i);

  // independent count of low-priority outstanding operations
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_out_q <= '0;
      rd_out_q <= '0;
    end else begin
      wr_out_q <= wr_out_q + (CNT_W+1)'(lp_acc && lp_req_op_i == 2'b01)
                  - (CNT_W+1)'(lp_wr_done_i && wr_out_q != 0);
      rd_out_q <= rd_out_q + (CNT_W+1)'(lp_acc && lp_req_op_i == 2'b00)
                  - (CNT_W+1)'(lp_rd_done_i && rd_out_q != 0);
    end
  end

  assert_hp_wr_enc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_acc && hp_req_wr_i) |-> (pkt_hi_o && pkt_cmd_o == 2'b01 && pkt_posted_o
                                 && pkt_pass_pw_o == hp_pass_pw_i && !pkt_resp_pass_pw_o));

  assert_lp_wr_enc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_acc && lp_req_op_i == 2'b01) |-> (!pkt_hi_o && pkt_cmd_o == 2'b01 && !pkt_posted_o
                                          && pkt_pass_pw_o && !pkt_resp_pass_pw_o));

  assert_rd_after_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_acc && lp_req_op_i == 2'b00) |-> (wr_out_q == 0));

  assert_flush_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_acc && lp_req_op_i == 2'b10) |-> (wr_out_q == 0));

  assert_fence_drain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_acc && lp_req_op_i == 2'b11) |-> (wr_out_q == 0 && rd_out_q == 0
                                          && !(pkt_valid_o && !pkt_hi_o)));

  assert_hp_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_acc |-> !(lp_acc && lp_pkt_op));

  assert_no_send_stalled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_ready_i |-> !(hp_acc || (lp_acc && lp_pkt_op)));

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_acc && lp_req_op_i == 2'b01) |-> (wr_out_q < MAX));
endmodule

bind agp_ht_xlat agp_ht_xlat_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .hp_pass_pw_i, .flush_pkt_i, .hp_req_valid_i, .hp_req_wr_i,
  .hp_req_ready_o, .lp_req_valid_i, .lp_req_op_i, .lp_req_ready_o, .pkt_valid_o,
  .pkt_ready_i, .pkt_cmd_o, .pkt_posted_o, .pkt_pass_pw_o, .pkt_resp_pass_pw_o,
  .pkt_hi_o, .lp_wr_done_i, .lp_rd_done_i
);

// File: tb/agp_ht_xlat_test.sv
`timescale 1ns/1ps
module agp_ht_xlat_test;
  localparam int CNT_W = 4;
  localparam int MAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic hp_pass_pw_i = 0, flush_pkt_i = 0;
  logic hp_req_valid_i = 0, hp_req_wr_i = 0, hp_req_ready_o;
  logic lp_req_valid_i = 0, lp_req_ready_o;
  logic [1:0] lp_req_op_i = 2'b00;
  logic pkt_valid_o, pkt_ready_i = 1, pkt_posted_o, pkt_pass_pw_o, pkt_resp_pass_pw_o, pkt_hi_o;
  logic [1:0] pkt_cmd_o;
  logic hp_wr_done_i = 0, hp_rd_done_i = 0, lp_wr_done_i = 0, lp_rd_done_i = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  agp_ht_xlat #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni, .hp_pass_pw_i, .flush_pkt_i, .hp_req_valid_i, .hp_req_wr_i,
    .hp_req_ready_o, .lp_req_valid_i, .lp_req_op_i, .lp_req_ready_o, .pkt_valid_o,
    .pkt_ready_i, .pkt_cmd_o, .pkt_posted_o, .pkt_pass_pw_o, .pkt_resp_pass_pw_o,
    .pkt_hi_o, .hp_wr_done_i, .hp_rd_done_i, .lp_wr_done_i, .lp_rd_done_i
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // {cmd, posted, pass_pw, resp_pass_pw} packed into 5 bits, checked as two parts
  task automatic chk_hdr(input string tag, input logic [1:0] cmd, input logic po,
                         input logic pw, input logic rpw, input logic hi);
    chk({tag, " valid"}, {3'b0, pkt_valid_o}, 4'd1);
    chk({tag, " cmd"}, {2'b0, pkt_cmd_o}, {2'b0, cmd});
    chk({tag, " attr"}, {pkt_hi_o, pkt_posted_o, pkt_pass_pw_o, pkt_resp_pass_pw_o},
        {hi, po, pw, rpw});
  endtask

  task automatic pulse(input logic [3:0] m);  // {hp_wr, hp_rd, lp_wr, lp_rd}
    @(negedge clk);
    {hp_wr_done_i, hp_rd_done_i, lp_wr_done_i, lp_rd_done_i} = m;
    @(negedge clk);
    {hp_wr_done_i, hp_rd_done_i, lp_wr_done_i, lp_rd_done_i} = 4'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R8 idle after reset", {3'b0, pkt_valid_o}, 4'd0);
    lp_req_valid_i = 1; lp_req_op_i = 2'b11;
    #1;
    chk("R8 fence ready after reset", {2'b0, lp_req_ready_o, pkt_valid_o}, 4'b0010);
    @(negedge clk); lp_req_valid_i = 0;
  endtask

  task automatic t_hp();
    @(negedge clk); hp_req_valid_i = 1; hp_req_wr_i = 1; hp_pass_pw_i = 1; #1;
    chk_hdr("R1 hp write", 2'b01, 1, 1, 0, 1);
    @(negedge clk); hp_req_wr_i = 0; hp_pass_pw_i = 0; #1;
    chk_hdr("R2 hp read", 2'b00, 0, 0, 1, 1);
    chk("R9 hp read with write outstanding", {3'b0, hp_req_ready_o}, 4'd1);
    @(negedge clk); hp_req_valid_i = 0;
    pulse(4'b1000); pulse(4'b0100);
  endtask

  task automatic t_lp();
    @(negedge clk); lp_req_valid_i = 1; lp_req_op_i = 2'b01; #1;
    chk_hdr("R3 lp write", 2'b01, 0, 1, 0, 0);
    @(negedge clk); lp_req_op_i = 2'b00; #1;
    chk("R5 read held behind write", {2'b0, lp_req_ready_o, pkt_valid_o}, 4'b0000);
    @(negedge clk); lp_wr_done_i = 1;
    @(negedge clk); lp_wr_done_i = 0; #1;
    chk("R5 read released", {3'b0, lp_req_ready_o}, 4'd1);
    chk_hdr("R4 lp read", 2'b00, 0, 1, 1, 0);
    @(negedge clk); lp_req_op_i = 2'b11; #1;
    chk("R8 fence waits on read", {2'b0, lp_req_ready_o, pkt_valid_o}, 4'b0000);
    @(negedge clk); lp_rd_done_i = 1;
    @(negedge clk); lp_rd_done_i = 0; #1;
    chk("R8 fence retires without packet", {2'b0, lp_req_ready_o, pkt_valid_o}, 4'b0010);
    @(negedge clk); lp_req_valid_i = 0;
  endtask

  task automatic t_flush();
    @(negedge clk); lp_req_valid_i = 1; lp_req_op_i = 2'b01; flush_pkt_i = 0;
    @(negedge clk); lp_req_op_i = 2'b10;
    hp_req_valid_i = 1; hp_req_wr_i = 1; hp_pass_pw_i = 1; #1;
    chk("R9 hp passes stalled flush", {lp_req_ready_o, hp_req_ready_o, pkt_valid_o, pkt_hi_o},
        4'b0111);
    @(negedge clk); hp_req_valid_i = 0; lp_wr_done_i = 1; #1;
    chk("R6 flush stalled, no packet", {2'b0, lp_req_ready_o, pkt_valid_o}, 4'b0000);
    @(negedge clk); lp_wr_done_i = 0; #1;
    chk("R6 flush retires without packet", {2'b0, lp_req_ready_o, pkt_valid_o}, 4'b0010);
    @(negedge clk); lp_req_op_i = 2'b01;
    @(negedge clk); lp_req_op_i = 2'b10; flush_pkt_i = 1; #1;
    chk("R7 alt flush waits on write", {2'b0, lp_req_ready_o, pkt_valid_o}, 4'b0000);
    @(negedge clk); lp_wr_done_i = 1;
    @(negedge clk); lp_wr_done_i = 0; #1;
    chk_hdr("R7 flush packet", 2'b10, 0, 0, 0, 0);
    chk("R7 flush accepted", {3'b0, lp_req_ready_o}, 4'd1);
    @(negedge clk); lp_req_valid_i = 0; flush_pkt_i = 0;
    pulse(4'b1000);
  endtask

  task automatic t_arb();
    @(negedge clk); hp_req_valid_i = 1; hp_req_wr_i = 0;
    lp_req_valid_i = 1; lp_req_op_i = 2'b01; #1;
    chk("R10 hp wins", {1'b0, pkt_hi_o, hp_req_ready_o, lp_req_ready_o}, 4'b0110);
    @(negedge clk); hp_req_valid_i = 0; #1;
    chk("R10 lp after hp", {pkt_hi_o, lp_req_ready_o, pkt_cmd_o}, 4'b0101);
    @(negedge clk); pkt_ready_i = 0; #1;
    chk("R10 backpressure", {2'b0, lp_req_ready_o, pkt_valid_o}, 4'b0001);
    @(negedge clk); pkt_ready_i = 1; lp_req_valid_i = 0;
    pulse(4'b0110);
  endtask

  task automatic t_sat();
    for (int i = 0; i < MAX; i++) begin
      @(negedge clk); lp_req_valid_i = 1; lp_req_op_i = 2'b01; #1;
      if (i == 0 || i == MAX - 1)
        chk("R12 back-to-back write", {3'b0, lp_req_ready_o}, 4'd1);
    end
    @(negedge clk); #1;
    chk("R11 write stalled at limit", {2'b0, lp_req_ready_o, pkt_valid_o}, 4'b0000);
    @(negedge clk); lp_wr_done_i = 1;
    @(negedge clk); lp_wr_done_i = 0; #1;
    chk("R11 write resumes", {3'b0, lp_req_ready_o}, 4'd1);
    @(negedge clk); lp_req_valid_i = 0;
    for (int i = 0; i < MAX; i++) pulse(4'b0010);
    @(negedge clk); lp_req_valid_i = 1; lp_req_op_i = 2'b11; #1;
    chk("R8 fence after drain", {3'b0, lp_req_ready_o}, 4'd1);
    @(negedge clk); lp_req_valid_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_hp();
    t_lp();
    t_flush();
    t_arb();
    t_sat();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule